// File: doc/BRIEF.md
# Dual-Channel Registered Bus Transceiver

This block links an A-side bus and a B-side bus through a set of independent byte-wide channels (two by default). Each channel can move data from A to B or from B to A. In each direction it can pass the value currently on the opposite side, or a value that was latched earlier into a holding register for that direction. Software-free control comes from per-channel pins. An active-low enable isolates both sides when high. A direction bit picks the driven side. Two capture strobes load the holding registers, and two select bits pick live or held data for each direction. Driving all channels with the same controls makes the block one wide path.

The pins that would be bidirectional are split into an input vector, an output vector and a per-bit output-enable vector for each side. A tri-state pad ring outside the block joins them. The whole block runs on one clock. Each capture strobe marks the cycle in which its direction's register loads. The driven data and the enables are registered, so every output is one clock behind the controls and data it follows. Because of this, a select change can never glitch a driven bit.

Top module: `bxr_dual_xcvr`

## Requirements
- R1: A synchronous active-high `rst` clears both holding registers of every channel to zero and, one clock later, leaves every bit of `a_oe` and `b_oe` at 0.
- R2: In a cycle where `cap_ab[c]` is 1, channel c's A-to-B register loads that channel's `a_in` byte at the clock edge, whatever `oe_n` and `dir` are; with `cap_ab[c]` at 0 the register holds.
- R3: In a cycle where `cap_ba[c]` is 1, channel c's B-to-A register loads that channel's `b_in` byte at the clock edge, whatever `oe_n` and `dir` are; with `cap_ba[c]` at 0 the register holds.
- R4: With `oe_n[c]` at 1 in a cycle, all bits of channel c's `a_oe` and `b_oe` bytes are 0 after the next edge (isolation), while capture still works.
- R5: With `oe_n[c]` at 0, `dir[c]` at 0 selects the A side as driven (all bits of the channel's `a_oe` byte 1, `b_oe` byte 0); `dir[c]` at 1 selects the B side as driven (the reverse), one clock later.
- R6: When the A side is driven, its data one clock later is the live `b_in` byte if `sel_ba[c]` is 0, or the B-to-A register content if `sel_ba[c]` is 1.
- R7: When the B side is driven, its data one clock later is the live `a_in` byte if `sel_ab[c]` is 0, or the A-to-B register content if `sel_ab[c]` is 1.
- R8: In no cycle does any channel have an `a_oe` bit and a `b_oe` bit asserted together.
- R9: Channel c uses bits [8c+7:8c] of every data and enable vector and only its own control bits. Channels do not affect one another, and equal controls on all channels act as one 16-bit path.
- R10: Driven data and enables are registered: a change on any input shows at the outputs exactly one clock later. Toggling a select while held and live data are equal leaves the driven value unchanged in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| oe_n | input | 2 | Per-channel active-low output enable |
| dir | input | 2 | Per-channel driven side: 0 = A, 1 = B |
| cap_ab | input | 2 | Per-channel strobe loading the A-to-B register |
| cap_ba | input | 2 | Per-channel strobe loading the B-to-A register |
| sel_ab | input | 2 | B-side source: 0 = live A, 1 = held A-to-B |
| sel_ba | input | 2 | A-side source: 0 = live B, 1 = held B-to-A |
| a_in | input | 16 | Value seen on the A side |
| b_in | input | 16 | Value seen on the B side |
| a_out | output | 16 | Data to drive onto the A side |
| a_oe | output | 16 | Per-bit drive enable for the A side |
| b_out | output | 16 | Data to drive onto the B side |
| b_oe | output | 16 | Per-bit drive enable for the B side |

## Verification
The hardest case to reach from the ports is a select toggling while held and live data are equal. From outside, that case cannot be told apart from no toggle at all unless the bench first arranges the equality. The stimulus loads a known byte through an isolated capture, drives the same byte live, flips the select every cycle and requires a constant output. It then changes the live byte and checks that the output moves exactly one edge later. A long run of mixed random controls, compared every cycle against a model in the bench, covers capture while isolated, direction swaps and channel independence.

// File: rtl/bxr_pkg.sv
package bxr_pkg;

  typedef enum logic [1:0] {
    PATH_ISOLATE = 2'd0,
    PATH_TO_A    = 2'd1,
    PATH_TO_B    = 2'd2
  } path_e;

  // Which side a channel drives, from its enable and direction controls.
  function automatic path_e path_decode(input logic oe_n, input logic dir);
    if (oe_n)     return PATH_ISOLATE;
    else if (dir) return PATH_TO_B;
    else          return PATH_TO_A;
  endfunction

endpackage

// File: rtl/bxr_store_reg.sv
module bxr_store_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)      q <= '0;
    else if (cap) q <= d;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (q == '0)); // R1
  AST_CAPTURE_LOAD: assert property (@(posedge clk) disable iff (rst)
    cap |=> (q == $past(d))); // R2, R3
  AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cap |=> $stable(q)); // R2, R3

endmodule

// File: rtl/bxr_port_drive.sv
module bxr_port_drive
  import bxr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         oe_n,
  input  logic         dir,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic [W-1:0] held_ab,
  input  logic [W-1:0] held_ba,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_oe
);

  // Source choice for one direction: live opposite side or held copy.
  function automatic logic [W-1:0] pick_src(input logic [W-1:0] live,
                                            input logic [W-1:0] held,
                                            input logic         use_held);
    return use_held ? held : live;
  endfunction

  path_e       path;
  logic        drive_a;
  logic        drive_b;
  logic [W-1:0] next_a;
  logic [W-1:0] next_b;

  always_comb begin
    path    = path_decode(oe_n, dir);
    drive_a = (path == PATH_TO_A);
    drive_b = (path == PATH_TO_B);
    next_a  = drive_a ? pick_src(b_in, held_ba, sel_ba) : '0;
    next_b  = drive_b ? pick_src(a_in, held_ab, sel_ab) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_out <= '0;
      b_out <= '0;
      a_oe  <= '0;
      b_oe  <= '0;
    end else begin
      a_out <= next_a;
      b_out <= next_b;
      a_oe  <= {W{drive_a}};
      b_oe  <= {W{drive_b}};
    end
  end

  AST_RESET_OE_OFF: assert property (@(posedge clk) rst |=> (a_oe == '0 && b_oe == '0)); // R1
  AST_ISOLATE: assert property (@(posedge clk) disable iff (rst)
    oe_n |=> (a_oe == '0 && b_oe == '0)); // R4
  AST_A_SIDE_DRIVEN: assert property (@(posedge clk) disable iff (rst)
    (!oe_n && !dir) |=> (&a_oe && b_oe == '0)); // R5
  AST_B_SIDE_DRIVEN: assert property (@(posedge clk) disable iff (rst)
    (!oe_n && dir) |=> (&b_oe && a_oe == '0)); // R5
  AST_A_LIVE: assert property (@(posedge clk) disable iff (rst)
    (!oe_n && !dir && !sel_ba) |=> (a_out == $past(b_in))); // R6
  AST_A_HELD: assert property (@(posedge clk) disable iff (rst)
    (!oe_n && !dir && sel_ba) |=> (a_out == $past(held_ba))); // R6
  AST_B_LIVE: assert property (@(posedge clk) disable iff (rst)
    (!oe_n && dir && !sel_ab) |=> (b_out == $past(a_in))); // R7
  AST_B_HELD: assert property (@(posedge clk) disable iff (rst)
    (!oe_n && dir && sel_ab) |=> (b_out == $past(held_ab))); // R7
  AST_NO_DUAL_DRIVE: assert property (@(posedge clk) disable iff (rst)
    !((|a_oe) && (|b_oe))); // R8
  AST_NO_SELECT_GLITCH: assert property (@(posedge clk) disable iff (rst)
    (!oe_n && dir && $past(!oe_n && dir) && held_ab == a_in
     && $past(held_ab == a_in) && $stable(a_in)) |=> $stable(b_out)); // R10

endmodule

// File: rtl/bxr_channel.sv
module bxr_channel #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         oe_n,
  input  logic         dir,
  input  logic         cap_ab,
  input  logic         cap_ba,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_oe
);

  logic [W-1:0] held_ab;
  logic [W-1:0] held_ba;

  bxr_store_reg #(.W(W)) u_store_ab (
    .clk(clk), .rst(rst), .cap(cap_ab), .d(a_in), .q(held_ab)
  );

  bxr_store_reg #(.W(W)) u_store_ba (
    .clk(clk), .rst(rst), .cap(cap_ba), .d(b_in), .q(held_ba)
  );

  bxr_port_drive #(.W(W)) u_drive (
    .clk(clk), .rst(rst), .oe_n(oe_n), .dir(dir),
    .sel_ab(sel_ab), .sel_ba(sel_ba),
    .a_in(a_in), .b_in(b_in), .held_ab(held_ab), .held_ba(held_ba),
    .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe)
  );

endmodule

// File: rtl/bxr_dual_xcvr.sv
module bxr_dual_xcvr #(
  parameter int NCH = 2,
  parameter int CW  = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NCH-1:0]      oe_n,
  input  logic [NCH-1:0]      dir,
  input  logic [NCH-1:0]      cap_ab,
  input  logic [NCH-1:0]      cap_ba,
  input  logic [NCH-1:0]      sel_ab,
  input  logic [NCH-1:0]      sel_ba,
  input  logic [NCH*CW-1:0]   a_in,
  input  logic [NCH*CW-1:0]   b_in,
  output logic [NCH*CW-1:0]   a_out,
  output logic [NCH*CW-1:0]   a_oe,
  output logic [NCH*CW-1:0]   b_out,
  output logic [NCH*CW-1:0]   b_oe
);

  localparam int BW = NCH * CW;

  // One channel per control bit, each owning its own byte lane (R9).
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    bxr_channel #(.W(CW)) u_ch (
      .clk(clk), .rst(rst),
      .oe_n(oe_n[c]), .dir(dir[c]),
      .cap_ab(cap_ab[c]), .cap_ba(cap_ba[c]),
      .sel_ab(sel_ab[c]), .sel_ba(sel_ba[c]),
      .a_in(a_in[c*CW +: CW]), .b_in(b_in[c*CW +: CW]),
      .a_out(a_out[c*CW +: CW]), .a_oe(a_oe[c*CW +: CW]),
      .b_out(b_out[c*CW +: CW]), .b_oe(b_oe[c*CW +: CW])
    );
  end

  AST_BUS_ONE_SIDE_PER_BIT: assert property (@(posedge clk) disable iff (rst)
    ((a_oe & b_oe) == {BW{1'b0}})); // R8

endmodule

// File: tb/bxr_dual_xcvr_tb.sv
`timescale 1ns/1ps
module bxr_dual_xcvr_tb_top;

  localparam int NCH = 2;
  localparam int CW  = 8;
  localparam int BW  = NCH * CW;

  logic          clk = 1'b0;
  logic          rst;
  logic [NCH-1:0] oe_n, dir, cap_ab, cap_ba, sel_ab, sel_ba;
  logic [BW-1:0] a_in, b_in;
  logic [BW-1:0] a_out, a_oe, b_out, b_oe;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bxr_dual_xcvr #(.NCH(NCH), .CW(CW)) dut_i (
    .clk(clk), .rst(rst), .oe_n(oe_n), .dir(dir),
    .cap_ab(cap_ab), .cap_ba(cap_ba), .sel_ab(sel_ab), .sel_ba(sel_ba),
    .a_in(a_in), .b_in(b_in),
    .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe)
  );

  // Bench model of the requirements.
  logic [CW-1:0] m_ab [NCH];
  logic [CW-1:0] m_ba [NCH];
  logic [CW-1:0] e_a  [NCH];
  logic [CW-1:0] e_b  [NCH];
  logic          e_aoe[NCH];
  logic          e_boe[NCH];

  task automatic expect_eq(input string req, input logic [BW-1:0] act,
                           input logic [BW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Advance one clock; the model steps from the inputs held across the edge.
  task automatic tick();
    logic [CW-1:0] n_ab [NCH];
    logic [CW-1:0] n_ba [NCH];
    for (int c = 0; c < NCH; c++) begin
      logic [CW-1:0] ai, bi;
      ai = a_in[c*CW +: CW];
      bi = b_in[c*CW +: CW];
      if (rst) begin
        n_ab[c] = '0; n_ba[c] = '0;
        e_aoe[c] = 0; e_boe[c] = 0; e_a[c] = '0; e_b[c] = '0;
      end else begin
        n_ab[c] = cap_ab[c] ? ai : m_ab[c];
        n_ba[c] = cap_ba[c] ? bi : m_ba[c];
        e_aoe[c] = !oe_n[c] && !dir[c];
        e_boe[c] = !oe_n[c] && dir[c];
        e_a[c]   = sel_ba[c] ? m_ba[c] : bi;
        e_b[c]   = sel_ab[c] ? m_ab[c] : ai;
      end
    end
    @(posedge clk);
    @(negedge clk);
    for (int c = 0; c < NCH; c++) begin
      m_ab[c] = n_ab[c];
      m_ba[c] = n_ba[c];
    end
  endtask

  // Compare every output lane with the model.
  task automatic compare_all(input string req);
    for (int c = 0; c < NCH; c++) begin
      expect_eq({req, " a_oe"}, BW'(a_oe[c*CW +: CW]), BW'({CW{e_aoe[c]}}));
      expect_eq({req, " b_oe"}, BW'(b_oe[c*CW +: CW]), BW'({CW{e_boe[c]}}));
      if (e_aoe[c]) expect_eq({req, " a_out"}, BW'(a_out[c*CW +: CW]), BW'(e_a[c]));
      if (e_boe[c]) expect_eq({req, " b_out"}, BW'(b_out[c*CW +: CW]), BW'(e_b[c]));
      checks++;
      if ((|a_oe[c*CW +: CW]) && (|b_oe[c*CW +: CW])) begin
        failures++;
        $display("FAIL R8 ch%0d both sides driven actual a_oe=%h b_oe=%h expected one zero",
                 c, a_oe[c*CW +: CW], b_oe[c*CW +: CW]);
      end
    end
  endtask

  task automatic idle();
    oe_n = '1; dir = '0; cap_ab = '0; cap_ba = '0; sel_ab = '0; sel_ba = '0;
  endtask

  task automatic t_reset();
    rst = 1; idle(); a_in = 16'hFFFF; b_in = 16'hFFFF; oe_n = '0;
    tick(); tick();
    expect_eq("R1 a_oe after reset", a_oe, '0);
    expect_eq("R1 b_oe after reset", b_oe, '0);
    rst = 0; oe_n = '0; dir = '0; sel_ba = '1;
    tick();
    expect_eq("R1 held B-to-A zero", a_out, '0);
    dir = '1; sel_ab = '1;
    tick();
    expect_eq("R1 held A-to-B zero", b_out, '0);
    compare_all("R1");
  endtask

  task automatic t_capture_isolated();
    idle(); a_in = 16'hA55A; b_in = 16'h3CC3; cap_ab = '1; cap_ba = '1;
    tick();
    expect_eq("R4 a_oe isolated", a_oe, '0);
    expect_eq("R4 b_oe isolated", b_oe, '0);
    cap_ab = '0; cap_ba = '0; a_in = 16'h0000; b_in = 16'h1111;
    oe_n = '0; dir = '1; sel_ab = '1;
    tick();
    expect_eq("R2 stored A-to-B", b_out, 16'hA55A);
    expect_eq("R5 b side driven", b_oe, 16'hFFFF);
    dir = '0; sel_ba = '1;
    tick();
    expect_eq("R3 stored B-to-A", a_out, 16'h3CC3);
    expect_eq("R5 a side driven", a_oe, 16'hFFFF);
    // Capture while driven in the opposite direction, then hold.
    dir = '0; cap_ab = '1; a_in = 16'h7E81;
    tick();
    cap_ab = '0; a_in = 16'h0F0F; dir = '1; sel_ab = '1;
    tick();
    expect_eq("R2 capture while A driven", b_out, 16'h7E81);
    tick();
    expect_eq("R2 hold without strobe", b_out, 16'h7E81);
    compare_all("R2 R3");
  endtask

  task automatic t_live();
    logic [BW-1:0] pats [4] = '{16'h0001, 16'h8000, 16'hFFFF, 16'h5A96};
    idle(); oe_n = '0;
    foreach (pats[i]) begin
      dir = '0; sel_ba = '0; b_in = pats[i]; a_in = ~pats[i];
      tick();
      expect_eq("R6 live B to A", a_out, pats[i]);
      dir = '1; sel_ab = '0;
      tick();
      expect_eq("R7 live A to B", b_out, ~pats[i]);
      compare_all("R6 R7");
    end
  endtask

  task automatic t_glitch_latency();
    idle(); a_in = 16'h5A5A; cap_ab = '1;
    tick();
    cap_ab = '0; oe_n = '0; dir = '1;
    for (int k = 0; k < 6; k++) begin
      sel_ab = {NCH{k[0]}};
      tick();
      expect_eq("R10 select toggle stable", b_out, 16'h5A5A);
    end
    sel_ab = '0; a_in = 16'h3333;
    expect_eq("R10 not yet changed", b_out, 16'h5A5A);
    tick();
    expect_eq("R10 changed after one clock", b_out, 16'h3333);
    oe_n = '1;
    expect_eq("R10 enable still on before edge", b_oe, 16'hFFFF);
    tick();
    expect_eq("R4 enable off after edge", b_oe, 16'h0000);
  endtask

  task automatic t_channels();
    idle();
    oe_n = 2'b00; dir = 2'b10; sel_ab = 2'b00; sel_ba = 2'b00;
    a_in = 16'hC3_12; b_in = 16'h44_E7;
    tick();
    expect_eq("R9 ch0 A driven lanes", a_oe, 16'h00FF);
    expect_eq("R9 ch1 B driven lanes", b_oe, 16'hFF00);
    expect_eq("R9 ch0 data", BW'(a_out[7:0]), 16'h00E7);
    expect_eq("R9 ch1 data", BW'(b_out[15:8]), 16'h00C3);
    oe_n = 2'b01;
    tick();
    expect_eq("R9 ch0 isolated only", a_oe | b_oe, 16'hFF00);
    // Ganged controls: one 16-bit path.
    oe_n = '0; dir = '1; sel_ab = '0; a_in = 16'hBEEF;
    tick();
    expect_eq("R9 ganged 16-bit", b_out, 16'hBEEF);
    compare_all("R9");
  endtask

  task automatic t_random();
    for (int n = 0; n < 400; n++) begin
      oe_n   = NCH'($urandom_range(0, 3));
      dir    = NCH'($urandom_range(0, 3));
      cap_ab = NCH'($urandom_range(0, 3));
      cap_ba = NCH'($urandom_range(0, 3));
      sel_ab = NCH'($urandom_range(0, 3));
      sel_ba = NCH'($urandom_range(0, 3));
      a_in   = BW'($urandom);
      b_in   = BW'($urandom);
      tick();
      compare_all("R2 R3 R5 R6 R7 R8 random");
    end
  endtask

  initial begin
    rst = 1; idle(); a_in = '0; b_in = '0;
    for (int c = 0; c < NCH; c++) begin
      m_ab[c] = '0; m_ba[c] = '0; e_a[c] = '0; e_b[c] = '0;
      e_aoe[c] = 0; e_boe[c] = 0;
    end
    @(negedge clk);
    t_reset();
    t_capture_isolated();
    t_live();
    t_glitch_latency();
    t_channels();
    t_random();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule